// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block is the memory-mapped control and status register file for a trusted-module command-response buffer interface. Software on a simple slave bus issues full-word writes and byte-granular reads into a 4 KiB window. The block holds the locality registers, two identification words, the control request/status/cancel/start registers, and the command and response buffer size and address registers. The buffer RAM itself starts at offset 0x80 and is not part of this block. Only locality 0 exists.

The block connects to a separate command engine through a one-cycle start pulse and a one-cycle cancel pulse. It takes back a completion strobe with an error flag. A start is accepted only while no command is in flight, and a cancel is forwarded only while one is. Completion clears the in-flight bit in hardware. A completion that carries an error latches a fatal-error bit, which only reset clears. Locality access requests are granted at once.

Top module: `cbr_regs`

## Requirements
- R1: A write of exactly 1 to the control request register (0x40) clears the idle flag (bit 1 of control status, 0x44) on the next cycle. A write of exactly 2 sets it. Any other value leaves it unchanged.
- R2: A write of exactly 1 to the start register (0x4C) while its invoke bit (bit 0) is 0 sets that bit and raises `cmd_start_o` for exactly one cycle, in the cycle after the write. If the bit is already 1, the write has no effect and no pulse is sent. This includes the case where a completion arrives in the same cycle.
- R3: A write of exactly 1 to the cancel register (0x48) raises `cmd_cancel_o` for one cycle, in the cycle after the write, only if the start invoke bit was 1 when the write was sampled. Otherwise the write is ignored.
- R4: Every cycle with `cmd_done_i` high clears the start invoke bit. If `cmd_err_i` is also high, the fatal-error bit (bit 0 of control status) is set and stays set until reset.
- R5: A write of exactly 1 to locality control (0x08) sets granted (bit 0) and clears been-seized (bit 1) in locality status (0x0C). It also sets locality-assigned (bit 1) and register-valid (bit 7) in locality state (0x00).
- R6: Locality control writes of any other value, including relinquish (2) and reset-establishment (8), change no state.
- R7: The identification low word (0x30) reads 0x00025811. Its fields are: interface type [3:0]=1, version [7:4]=1, locality-0-only [8]=0, idle bypass [9]=0, transfer size [12:11]=3, FIFO [13]=0, buffer capable [14]=1, selector [18:17]=1, revision [31:24]=0. The high word (0x34) reads the `ID_HI_WORD` parameter (default 0).
- R8: Command size (0x58) and response size (0x64) both read the window size minus 0x80, which is 0xF80 by default. Command address (0x5C) and response address (0x68) both read `BASE_ADDR` + 0x80, which is 0x40000080 by default.
- R9: A read returns the aligned 32-bit word shifted right by 8 times address bits [1:0], giving little-endian byte lanes. `bus_rdata` is combinational and is zero when no read is requested.
- R10: Writes to unlisted offsets, and to the identification, size and address registers, change nothing. Reads of unlisted offsets return zero.
- R11: After reset, idle is 1, fatal is 0, invoke is 0, all locality bits are 0 and neither pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = full-word write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, lane-shifted |
| cmd_start_o | output | 1 | One-cycle start request to the command engine |
| cmd_cancel_o | output | 1 | One-cycle cancel request to the command engine |
| cmd_done_i | input | 1 | Completion strobe from the command engine |
| cmd_err_i | input | 1 | Completion carried an error |

## Verification
The bench sends a second start while a command is in flight. A block that does not gate on the invoke bit would pulse again. It sends a start in the same cycle as a completion, which a block with the wrong priority would accept or leave stuck. It cancels both in flight and when idle; a block without the gate pulses cancel with nothing running. It checks that fatal error survives later clean completions, that codes other than the exact values leave idle and locality state untouched, and that byte-offset reads land on the right lanes rather than returning the whole word.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;

    // byte offsets inside the register window
    localparam logic [7:0] OFF_LOC_STATE = 8'h00;
    localparam logic [7:0] OFF_LOC_CTRL  = 8'h08;
    localparam logic [7:0] OFF_LOC_STS   = 8'h0C;
    localparam logic [7:0] OFF_ID_LO     = 8'h30;
    localparam logic [7:0] OFF_ID_HI     = 8'h34;
    localparam logic [7:0] OFF_CTRL_REQ  = 8'h40;
    localparam logic [7:0] OFF_CTRL_STS  = 8'h44;
    localparam logic [7:0] OFF_CANCEL    = 8'h48;
    localparam logic [7:0] OFF_START     = 8'h4C;
    localparam logic [7:0] OFF_CMD_SIZE  = 8'h58;
    localparam logic [7:0] OFF_CMD_ADDR  = 8'h5C;
    localparam logic [7:0] OFF_RSP_SIZE  = 8'h64;
    localparam logic [7:0] OFF_RSP_ADDR  = 8'h68;
    localparam logic [7:0] OFF_DATA      = 8'h80;

    // write codes
    localparam logic [31:0] REQ_CMD_READY   = 32'd1;
    localparam logic [31:0] REQ_GO_IDLE     = 32'd2;
    localparam logic [31:0] START_INVOKE    = 32'd1;
    localparam logic [31:0] CANCEL_INVOKE   = 32'd1;
    localparam logic [31:0] LOC_REQ_ACCESS  = 32'd1;
    localparam logic [31:0] LOC_RELINQUISH  = 32'd2;
    localparam logic [31:0] LOC_RESET_ESTAB = 32'd8;

    // bit positions
    localparam int LST_ASSIGNED = 1;
    localparam int LST_REGVALID = 7;
    localparam int LSS_GRANTED  = 0;
    localparam int LSS_SEIZED   = 1;
    localparam int CS_FATAL     = 0;
    localparam int CS_IDLE      = 1;

    // identification word fields
    localparam logic [3:0] ID_TYPE_ACTIVE = 4'd1;
    localparam logic [3:0] ID_VERSION     = 4'd1;
    localparam logic [1:0] ID_XFER_64     = 2'd3;
    localparam logic [1:0] ID_SEL_BUFFER  = 2'd1;
    localparam logic [7:0] ID_REVISION    = 8'd0;

    function automatic logic [31:0] ident_word();
        logic [31:0] w;
        w        = '0;
        w[3:0]   = ID_TYPE_ACTIVE;
        w[7:4]   = ID_VERSION;
        w[8]     = 1'b0;          // locality 0 only
        w[9]     = 1'b0;          // no idle bypass
        w[12:11] = ID_XFER_64;
        w[13]    = 1'b0;          // FIFO not supported
        w[14]    = 1'b1;          // buffer interface supported
        w[18:17] = ID_SEL_BUFFER;
        w[31:24] = ID_REVISION;
        return w;
    endfunction

    typedef struct packed {
        logic granted;
        logic seized;
        logic assigned;
        logic regvalid;
    } loc_state_t;

    typedef struct packed {
        logic idle;
        logic fatal;
        logic invoke;
        logic start_p;
        logic cancel_p;
    } cmd_state_t;

endpackage

// File: rtl/cbr_locality.sv
`timescale 1ns/1ps
module cbr_locality
    import cbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] state_word_o,
    output logic [31:0] sts_word_o
);

    loc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl_i) begin
            case (wdata_i)
                LOC_REQ_ACCESS: begin
                    st_d.granted  = 1'b1;
                    st_d.seized   = 1'b0;
                    st_d.assigned = 1'b1;
                    st_d.regvalid = 1'b1;
                end
                LOC_RELINQUISH:  ;   // single locality: nothing to give up
                LOC_RESET_ESTAB: ;   // not permitted from locality 0
                default:         ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        state_word_o               = '0;
        state_word_o[LST_ASSIGNED] = st_q.assigned;
        state_word_o[LST_REGVALID] = st_q.regvalid;
        sts_word_o                 = '0;
        sts_word_o[LSS_GRANTED]    = st_q.granted;
        sts_word_o[LSS_SEIZED]     = st_q.seized;
    end

    p_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && wdata_i == LOC_REQ_ACCESS) |=>
        (st_q.granted && !st_q.seized && st_q.assigned && st_q.regvalid));

    p_other_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && wdata_i != LOC_REQ_ACCESS) |=> $stable(st_q));

endmodule

// File: rtl/cbr_cmd_ctrl.sv
`timescale 1ns/1ps
module cbr_cmd_ctrl
    import cbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_req_i,
    input  logic        wr_cancel_i,
    input  logic        wr_start_i,
    input  logic [31:0] wdata_i,
    input  logic        done_i,
    input  logic        err_i,
    output logic [31:0] sts_word_o,
    output logic [31:0] start_word_o,
    output logic        start_o,
    output logic        cancel_o
);

    localparam cmd_state_t CMD_RESET = '{idle: 1'b1, fatal: 1'b0, invoke: 1'b0,
                                         start_p: 1'b0, cancel_p: 1'b0};

    cmd_state_t st_d, st_q;
    logic       accept_start;
    logic       accept_cancel;

    always_comb begin
        st_d          = st_q;
        accept_start  = wr_start_i  && (wdata_i == START_INVOKE)  && !st_q.invoke;
        accept_cancel = wr_cancel_i && (wdata_i == CANCEL_INVOKE) &&  st_q.invoke;

        if (wr_req_i) begin
            case (wdata_i)
                REQ_CMD_READY: st_d.idle = 1'b0;
                REQ_GO_IDLE:   st_d.idle = 1'b1;
                default:       ;
            endcase
        end

        if (done_i) begin
            st_d.invoke = 1'b0;
            if (err_i) st_d.fatal = 1'b1;
        end
        if (accept_start) st_d.invoke = 1'b1;

        st_d.start_p  = accept_start;
        st_d.cancel_p = accept_cancel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CMD_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        sts_word_o           = '0;
        sts_word_o[CS_FATAL] = st_q.fatal;
        sts_word_o[CS_IDLE]  = st_q.idle;
        start_word_o         = '0;
        start_word_o[0]      = st_q.invoke;
    end

    assign start_o  = st_q.start_p;
    assign cancel_o = st_q.cancel_p;

    p_ready_clears_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wdata_i == REQ_CMD_READY) |=> !st_q.idle);

    p_goidle_sets_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wdata_i == REQ_GO_IDLE) |=> st_q.idle);

    p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    p_start_marks_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> st_q.invoke);

    p_cancel_inflight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> $past(st_q.invoke));

    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && st_q.invoke) |=> !st_q.invoke);

    p_fatal_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fatal |=> st_q.fatal);

endmodule

// File: rtl/cbr_read_mux.sv
`timescale 1ns/1ps
module cbr_read_mux
    import cbr_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter logic [31:0] ID_LO_WORD = 32'h0,
    parameter logic [31:0] ID_HI_WORD = 32'h0,
    parameter logic [31:0] BUF_SIZE   = 32'h0,
    parameter logic [31:0] BUF_ADDR   = 32'h0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic [31:0]       loc_state_i,
    input  logic [31:0]       loc_sts_i,
    input  logic [31:0]       ctrl_sts_i,
    input  logic [31:0]       start_word_i,
    output logic [31:0]       rdata_o
);

    localparam int WA = ADDR_W - 2;

    logic [WA-1:0] idx;
    logic [1:0]    lane;
    logic [31:0]   word;

    assign idx  = addr_i[ADDR_W-1:2];
    assign lane = addr_i[1:0];

    always_comb begin
        word = '0;
        case (idx)
            WA'(OFF_LOC_STATE >> 2): word = loc_state_i;
            WA'(OFF_LOC_STS   >> 2): word = loc_sts_i;
            WA'(OFF_ID_LO     >> 2): word = ID_LO_WORD;
            WA'(OFF_ID_HI     >> 2): word = ID_HI_WORD;
            WA'(OFF_CTRL_STS  >> 2): word = ctrl_sts_i;
            WA'(OFF_START     >> 2): word = start_word_i;
            WA'(OFF_CMD_SIZE  >> 2): word = BUF_SIZE;
            WA'(OFF_CMD_ADDR  >> 2): word = BUF_ADDR;
            WA'(OFF_RSP_SIZE  >> 2): word = BUF_SIZE;
            WA'(OFF_RSP_ADDR  >> 2): word = BUF_ADDR;
            default:                 word = '0;
        endcase
        rdata_o = rd_en_i ? (word >> {lane, 3'b000}) : '0;
    end

endmodule

// File: rtl/cbr_regs.sv
`timescale 1ns/1ps
module cbr_regs
    import cbr_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter logic [31:0] ID_HI_WORD = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cmd_start_o,
    output logic              cmd_cancel_o,
    input  logic              cmd_done_i,
    input  logic              cmd_err_i
);

    localparam int          WA         = ADDR_W - 2;
    localparam logic [31:0] WINDOW     = 32'(1) << ADDR_W;
    localparam logic [31:0] BUF_SIZE   = WINDOW - 32'(OFF_DATA);
    localparam logic [31:0] BUF_ADDR   = BASE_ADDR + 32'(OFF_DATA);
    localparam logic [31:0] ID_LO_WORD = ident_word();

    logic [WA-1:0] widx;
    logic          wr_en;
    logic          rd_en;
    logic          wr_loc_ctrl;
    logic          wr_req;
    logic          wr_cancel;
    logic          wr_start;
    logic [31:0]   loc_state_w;
    logic [31:0]   loc_sts_w;
    logic [31:0]   ctrl_sts_w;
    logic [31:0]   start_w;

    assign widx  = bus_addr[ADDR_W-1:2];
    assign wr_en = bus_valid &  bus_write;
    assign rd_en = bus_valid & ~bus_write;

    assign wr_loc_ctrl = wr_en && (widx == WA'(OFF_LOC_CTRL >> 2));
    assign wr_req      = wr_en && (widx == WA'(OFF_CTRL_REQ >> 2));
    assign wr_cancel   = wr_en && (widx == WA'(OFF_CANCEL   >> 2));
    assign wr_start    = wr_en && (widx == WA'(OFF_START    >> 2));

    cbr_locality u_loc (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctrl_i    (wr_loc_ctrl),
        .wdata_i      (bus_wdata),
        .state_word_o (loc_state_w),
        .sts_word_o   (loc_sts_w)
    );

    cbr_cmd_ctrl u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req_i     (wr_req),
        .wr_cancel_i  (wr_cancel),
        .wr_start_i   (wr_start),
        .wdata_i      (bus_wdata),
        .done_i       (cmd_done_i),
        .err_i        (cmd_err_i),
        .sts_word_o   (ctrl_sts_w),
        .start_word_o (start_w),
        .start_o      (cmd_start_o),
        .cancel_o     (cmd_cancel_o)
    );

    cbr_read_mux #(
        .ADDR_W     (ADDR_W),
        .ID_LO_WORD (ID_LO_WORD),
        .ID_HI_WORD (ID_HI_WORD),
        .BUF_SIZE   (BUF_SIZE),
        .BUF_ADDR   (BUF_ADDR)
    ) u_rd (
        .addr_i       (bus_addr),
        .rd_en_i      (rd_en),
        .loc_state_i  (loc_state_w),
        .loc_sts_i    (loc_sts_w),
        .ctrl_sts_i   (ctrl_sts_w),
        .start_word_i (start_w),
        .rdata_o      (bus_rdata)
    );

    p_pulses_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_start_o && cmd_cancel_o));

endmodule

// File: tb/cbr_regs_bench.sv
`timescale 1ns/1ps
module cbr_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_start_o;
    logic        cmd_cancel_o;
    logic        cmd_done_i = 1'b0;
    logic        cmd_err_i = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit cmp_on   = 1'b0;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    cbr_regs u_cbr_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .cmd_start_o  (cmd_start_o),
        .cmd_cancel_o (cmd_cancel_o),
        .cmd_done_i   (cmd_done_i),
        .cmd_err_i    (cmd_err_i)
    );

    // ---------------- reference model ----------------
    bit m_idle, m_fatal, m_busy, m_start_p, m_cancel_p;
    bit m_granted, m_seized, m_assigned, m_valid;

    always @(posedge clk) begin
        bit take_start;
        int a;
        take_start = 1'b0;
        if (!rst_n) begin
            m_idle = 1; m_fatal = 0; m_busy = 0; m_start_p = 0; m_cancel_p = 0;
            m_granted = 0; m_seized = 0; m_assigned = 0; m_valid = 0;
        end else begin
            m_start_p  = 0;
            m_cancel_p = 0;
            if (bus_valid && bus_write) begin
                a = int'(bus_addr) & 32'hFFC;
                if (a == 'h40 && bus_wdata == 1) m_idle = 0;
                if (a == 'h40 && bus_wdata == 2) m_idle = 1;
                if (a == 'h4C && bus_wdata == 1 && !m_busy) take_start = 1;
                if (a == 'h48 && bus_wdata == 1 && m_busy) m_cancel_p = 1;
                if (a == 'h08 && bus_wdata == 1) begin
                    m_granted = 1; m_seized = 0; m_assigned = 1; m_valid = 1;
                end
            end
            if (cmd_done_i) begin
                m_busy = 0;
                if (cmd_err_i) m_fatal = 1;
            end
            if (take_start) begin
                m_busy = 1;
                m_start_p = 1;
            end
        end
    end

    function automatic logic [31:0] model_word(input int a);
        case (a & 32'hFFC)
            'h00: return (32'(m_valid) << 7) | (32'(m_assigned) << 1);
            'h0C: return (32'(m_seized) << 1) | 32'(m_granted);
            'h30: return 32'h1 | (32'h1 << 4) | (32'h3 << 11) | (32'h1 << 14) | (32'h1 << 17);
            'h34: return 32'h0;
            'h44: return (32'(m_idle) << 1) | 32'(m_fatal);
            'h4C: return 32'(m_busy);
            'h58, 'h64: return 32'd4096 - 32'h80;
            'h5C, 'h68: return 32'h4000_0000 + 32'h80;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input int a);
        return model_word(a) >> (8 * (a & 3));
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // pulses compared against the model on every clock
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R2 start pulse", 32'(cmd_start_o), 32'(m_start_p));
            chk("R3 cancel pulse", 32'(cmd_cancel_o), 32'(m_cancel_p));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 12'(a); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 12'(a);
        #1;
        chk(tag, bus_rdata, model_read(a));
        bus_valid = 0;
    endtask

    task automatic rdx(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 12'(a);
        #1;
        chk(tag, bus_rdata, exp);
        bus_valid = 0;
    endtask

    task automatic done(input bit err);
        @(negedge clk);
        cmd_done_i = 1; cmd_err_i = err;
        @(negedge clk);
        cmd_done_i = 0; cmd_err_i = 0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;

        // R11 / R7 / R8 reset contents
        rdx('h00, 32'h0, "R11 locality state after reset");
        rdx('h0C, 32'h0, "R11 locality status after reset");
        rdx('h44, 32'h2, "R11 control status after reset");
        rdx('h4C, 32'h0, "R11 start after reset");
        rdx('h30, 32'h0002_5811, "R7 identification low word");
        rdx('h34, 32'h0, "R7 identification high word");
        rdx('h58, 32'h0000_0F80, "R8 command size");
        rdx('h64, 32'h0000_0F80, "R8 response size");
        rdx('h5C, 32'h4000_0080, "R8 command address");
        rdx('h68, 32'h4000_0080, "R8 response address");

        // R9 byte lanes
        rdx('h31, 32'h0000_0258, "R9 lane 1 read");
        rdx('h32, 32'h0000_0002, "R9 lane 2 read");
        rdx('h33, 32'h0000_0000, "R9 lane 3 read");
        rdx('h59, 32'h0000_000F, "R9 size lane 1");
        rd ('h6B, "R9 address lane 3");

        // R1 control request codes
        wr('h40, 32'd1);  rdx('h44, 32'h0, "R1 ready clears idle");
        wr('h40, 32'd3);  rdx('h44, 32'h0, "R1 code 3 ignored");
        wr('h40, 32'h101); rdx('h44, 32'h0, "R1 code 0x101 ignored");
        wr('h40, 32'd2);  rdx('h44, 32'h2, "R1 go-idle sets idle");

        // R2 start, R3 cancel, R4 completion
        wr('h48, 32'd1);  rdx('h4C, 32'h0, "R3 cancel while idle ignored");
        wr('h4C, 32'd1);  rdx('h4C, 32'h1, "R2 start sets invoke");
        wr('h4C, 32'd1);  rdx('h4C, 32'h1, "R2 second start ignored");
        wr('h48, 32'd2);  rd('h4C, "R3 cancel code 2 ignored");
        wr('h48, 32'd1);  rd('h4C, "R3 cancel in flight");
        done(1'b0);
        rdx('h4C, 32'h0, "R4 completion clears invoke");
        rdx('h44, 32'h2, "R4 clean completion no fatal");
        wr('h48, 32'd1);  rd('h4C, "R3 cancel after completion ignored");
        wr('h4C, 32'd5);  rdx('h4C, 32'h0, "R2 start code 5 ignored");

        wr('h4C, 32'd1);
        done(1'b1);
        rdx('h44, 32'h3, "R4 error sets fatal");
        rdx('h4C, 32'h0, "R4 error completion clears invoke");
        wr('h4C, 32'd1);
        done(1'b0);
        rdx('h44, 32'h3, "R4 fatal sticky after clean completion");

        // R2 start written in the same cycle as completion while busy
        wr('h4C, 32'd1);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 12'h04C; bus_wdata = 32'd1;
        cmd_done_i = 1;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; cmd_done_i = 0;
        rdx('h4C, 32'h0, "R2 start with completion rejected");
        wr('h4C, 32'd1);  rdx('h4C, 32'h1, "R2 start accepted after completion");
        done(1'b0);

        // R6 locality codes that change nothing
        wr('h08, 32'd2);  rdx('h0C, 32'h0, "R6 relinquish no change");
        wr('h08, 32'd8);  rdx('h00, 32'h0, "R6 reset-establishment no change");
        wr('h08, 32'd3);  rdx('h0C, 32'h0, "R6 combined code no change");
        // R5 request access
        wr('h08, 32'd1);
        rdx('h0C, 32'h1, "R5 granted set, seized clear");
        rdx('h00, 32'h82, "R5 assigned and register-valid set");
        wr('h08, 32'd2);  rdx('h00, 32'h82, "R6 relinquish keeps grant");

        // R10 ignored writes and unused reads
        wr('h30, 32'hFFFF_FFFF); rdx('h30, 32'h0002_5811, "R10 id write ignored");
        wr('h58, 32'h0);         rdx('h58, 32'h0000_0F80, "R10 size write ignored");
        wr('h44, 32'h0);         rdx('h44, 32'h3, "R10 status write ignored");
        wr('h10, 32'h1);         rdx('h10, 32'h0, "R10 unused offset reads zero");
        wr('h84, 32'h1);         rdx('h0C, 32'h1, "R10 buffer-offset write ignored");
        rdx('h20, 32'h0, "R10 unused offset 0x20 reads zero");

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule